// File: doc/BRIEF.md
# Per-Core Timer Register Router

This block sits between a shared register request channel and a set of private timers, one timer per processor core. Every request carries the identity of the core that issued it. The address space is cut into 32-byte windows. Window 0 is an alias: it always reaches the timer that belongs to the issuing core. Each later window reaches one fixed timer, whatever core issues the request. The router decodes each request and drives a one-hot select, a write enable, a word offset and write data toward the timers. It returns the selected timer's read data on a response channel and forwards each timer's interrupt line as one registered output bit per core.

Requests and responses both use valid/ready handshakes. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The router holds one response. `req_ready` stays high while no response is pending, or while the pending response is being taken in that same cycle. This means a stalled response channel stalls the request channel. A pending response keeps its data and error bit unchanged until `rsp_ready` takes it.

Some requests are refused: an access that is not a full aligned 32-bit word, an alias access from a core that has no timer, or an access to a window with no timer behind it. A refused request never touches a timer. It returns zero data with the error bit set, and it pulses a separate error flag for one cycle.

Top module: `tmr_bank_router`

## Requirements
- R1: A request to window 0 (address bits [ADDR_W-1:5] equal to 0) selects the timer whose index equals `req_core`, provided `req_core` is below NUM_CORES.
- R2: A request to window w, for 1 <= w <= NUM_CORES, selects timer w-1, whatever the value of `req_core`.
- R3: Address bits [4:2] are passed to the selected timer as the word offset `tmr_off`. For an accepted write, `tmr_wdata` carries `req_wdata` and `tmr_we` is high.
- R4: A request whose byte enables are not 4'b1111, or whose address bits [1:0] are not 00, is refused. It selects no timer, so a refused write leaves timer state unchanged. Its response carries `rsp_err`=1 and `rsp_rdata`=0.
- R5: A window-0 request from a `req_core` value of NUM_CORES or above is refused, with the same response as in R4.
- R6: A request to a window index above NUM_CORES is refused, with the same response as in R4.
- R7: `acc_err` is high in exactly the cycle after a refused request is accepted, and is low after any other cycle.
- R8: While a response is pending and `rsp_ready` is low, `req_ready` is low, and `rsp_rdata` and `rsp_err` hold their values.
- R9: At most one bit of `tmr_sel` is high in a cycle. A bit is high only in a cycle where a request is accepted.
- R10: `irq_o[k]` equals `tmr_irq[k]` as it was one clock earlier.
- R11: After reset, `rsp_valid`, `acc_err` and `irq_o` are 0, and `req_ready` is 1.
- R12: The response to an accepted write carries `rsp_rdata`=0 and `rsp_err`=0. The response to an accepted read carries the word the selected timer presents on `tmr_rdata` in the accept cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_core | input | CID_W | Identity of the issuing core |
| req_addr | input | ADDR_W | Byte address inside the router's range |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables; only 4'b1111 is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, 0 for writes and refusals |
| rsp_err | output | 1 | Request was refused |
| acc_err | output | 1 | One-cycle pulse per refused request |
| tmr_sel | output | NUM_CORES | One-hot timer select, bit k = timer k |
| tmr_we | output | 1 | Write strobe to the selected timer |
| tmr_off | output | 3 | Word offset inside the timer window |
| tmr_wdata | output | 32 | Write data to the timers |
| tmr_rdata | input | 32*NUM_CORES | Read words; timer k on bits [32k+31:32k] |
| tmr_irq | input | NUM_CORES | Interrupt from each timer |
| irq_o | output | NUM_CORES | Registered interrupt per core, ordered by core index |

## Verification
Two things can happen in the same clock edge: a stalled response is handed off, and the next request is accepted. To provoke this, the bench holds `rsp_ready` low while a second write waits on the request channel. It then raises `rsp_ready`, so the edge that takes the first response also accepts the waiting write. The bench judges the result in three ways. The first response must stay stable until that edge. The write must land in its timer exactly once. The new response must follow in the next cycle. Separately, a refusal and a legal access are placed back to back, to show that `acc_err` stays a single-cycle pulse tied only to the refused request.

// File: rtl/tmr_rtr_pkg.sv
package tmr_rtr_pkg;
  localparam int WIN_BYTES = 32;
  localparam int WIN_LSB   = 5;
  localparam int OFF_W     = 3;
  localparam int WORD_W    = 32;
  localparam int BE_W      = 4;

  typedef enum logic [1:0] {
    DEC_OK   = 2'd0,
    DEC_SIZE = 2'd1,
    DEC_CORE = 2'd2,
    DEC_WIN  = 2'd3
  } dec_kind_e;
endpackage

// File: rtl/tmr_rtr_decode.sv
module tmr_rtr_decode
  import tmr_rtr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int MAX_CORES = 8,
  parameter int ADDR_W    = 12,
  localparam int CID_W    = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1,
  localparam int WIN_W    = ADDR_W - WIN_LSB
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [CID_W-1:0]  core,
  output dec_kind_e         kind,
  output logic [CID_W-1:0]  tgt,
  output logic [OFF_W-1:0]  off
);
  logic [WIN_W-1:0] win;
  logic             core_ok;
  logic             win_ok;
  logic [CID_W-1:0] fixed_tgt;

  assign win     = addr[ADDR_W-1:WIN_LSB];
  assign off     = addr[WIN_LSB-1:2];
  assign core_ok = ({1'b0, core} < (CID_W+1)'(NUM_CORES));

  always_comb begin
    win_ok    = 1'b0;
    fixed_tgt = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (win == WIN_W'(k + 1)) begin
        win_ok    = 1'b1;
        fixed_tgt = CID_W'(k);
      end
    end
  end

  always_comb begin
    tgt  = '0;
    kind = DEC_OK;
    if (be != {BE_W{1'b1}} || addr[1:0] != 2'b00) begin
      kind = DEC_SIZE;
    end else if (win == '0) begin
      if (core_ok) tgt = core;
      else         kind = DEC_CORE;
    end else if (win_ok) begin
      tgt = fixed_tgt;
    end else begin
      kind = DEC_WIN;
    end
  end
endmodule

// File: rtl/tmr_rtr_rsp.sv
module tmr_rtr_rsp
  import tmr_rtr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              refused,
  input  logic              is_write,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              acc_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      acc_err   <= 1'b0;
    end else begin
      acc_err <= fire && refused;
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_err   <= refused;
        rsp_rdata <= (refused || is_write) ? '0 : rd_word;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0); // R4

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R8

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(fire)); // R7
endmodule

// File: rtl/tmr_rtr_irq.sv
module tmr_rtr_irq #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] irq_in,
  output logic [NUM_CORES-1:0] irq_out
);
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out[k] <= 1'b0;
      else        irq_out[k] <= irq_in[k];
    end
  end

  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(!rst_n) |-> irq_out == $past(irq_in)); // R10
endmodule

// File: rtl/tmr_bank_router.sv
module tmr_bank_router
  import tmr_rtr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int MAX_CORES = 8,
  parameter int ADDR_W    = 12,
  localparam int CID_W    = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [CID_W-1:0]            req_core,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic                        req_we,
  input  logic [BE_W-1:0]             req_be,
  input  logic [WORD_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [WORD_W-1:0]           rsp_rdata,
  output logic                        rsp_err,
  output logic                        acc_err,
  output logic [NUM_CORES-1:0]        tmr_sel,
  output logic                        tmr_we,
  output logic [OFF_W-1:0]            tmr_off,
  output logic [WORD_W-1:0]           tmr_wdata,
  input  logic [NUM_CORES*WORD_W-1:0] tmr_rdata,
  input  logic [NUM_CORES-1:0]        tmr_irq,
  output logic [NUM_CORES-1:0]        irq_o
);
  dec_kind_e         kind;
  logic [CID_W-1:0]  tgt;
  logic              fire;
  logic              refused;
  logic [WORD_W-1:0] rd_word;

  tmr_rtr_decode #(
    .NUM_CORES(NUM_CORES), .MAX_CORES(MAX_CORES), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(req_addr), .be(req_be), .core(req_core),
    .kind(kind), .tgt(tgt), .off(tmr_off)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign refused   = (kind != DEC_OK);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_sel
    assign tmr_sel[k] = fire && !refused && (tgt == CID_W'(k));
  end

  assign tmr_we    = req_we && (|tmr_sel);
  assign tmr_wdata = req_wdata;

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (tgt == CID_W'(k)) rd_word = tmr_rdata[k*WORD_W +: WORD_W];
    end
  end

  tmr_rtr_rsp u_rsp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .refused(refused),
    .is_write(req_we), .rd_word(rd_word), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .acc_err(acc_err)
  );

  tmr_rtr_irq #(.NUM_CORES(NUM_CORES)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_in(tmr_irq), .irq_out(irq_o)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_sel)); // R9

  AST_SEL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    |tmr_sel |-> req_valid && req_ready); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R8

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R12
endmodule

// File: tb/sim_tmr_bank_router.sv
module sim_tmr_bank_router;
  localparam int N  = 4;
  localparam int MX = 8;
  localparam int AW = 12;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [CW-1:0]   req_core = '0;
  logic [AW-1:0]   req_addr = '0;
  logic            req_we = 1'b0;
  logic [3:0]      req_be = 4'hF;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [31:0]     rsp_rdata;
  logic            rsp_err;
  logic            acc_err;
  logic [N-1:0]    tmr_sel;
  logic            tmr_we;
  logic [2:0]      tmr_off;
  logic [31:0]     tmr_wdata;
  logic [N*32-1:0] tmr_rdata;
  logic [N-1:0]    tmr_irq;
  logic [N-1:0]    irq_o;

  tmr_bank_router #(.NUM_CORES(N), .MAX_CORES(MX), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_addr(req_addr), .req_we(req_we), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .acc_err(acc_err),
    .tmr_sel(tmr_sel), .tmr_we(tmr_we), .tmr_off(tmr_off),
    .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata), .tmr_irq(tmr_irq),
    .irq_o(irq_o)
  );

  // Timer stub: eight words per timer, interrupt = bit 0 of word 3
  logic [31:0] stub [N][8];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) for (int j = 0; j < 8; j++) stub[k][j] <= '0;
    end else begin
      for (int k = 0; k < N; k++) if (tmr_sel[k] && tmr_we) stub[k][tmr_off] <= tmr_wdata;
    end
  end
  always_comb begin
    for (int k = 0; k < N; k++) begin
      tmr_rdata[k*32 +: 32] = stub[k][tmr_off];
      tmr_irq[k]            = stub[k][3][0];
    end
  end

  // Reference model
  int unsigned mdl [N][8];
  logic [N-1:0] exp_irq = '0;
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle monitor: interrupt delay and select discipline
  always @(posedge clk) exp_irq <= rst_n ? tmr_irq : '0;
  always @(negedge clk) if (rst_n) begin
    chk(irq_o == exp_irq, "R10 irq_o", irq_o, exp_irq);
    chk($countones(tmr_sel) <= 1, "R9 sel count", tmr_sel, 0);
    chk(tmr_sel == '0 || (req_valid && req_ready), "R9 sel no accept", tmr_sel, 0);
  end

  function automatic logic [AW-1:0] wa(input int w, input int o);
    return AW'(w * 32 + o * 4);
  endfunction

  // One access with rsp_ready high; checks the response against the model
  task automatic access(input string tag, input int core, input int w, input int o,
                        input bit we, input logic [31:0] d, input logic [3:0] be,
                        input bit mis);
    int  tgt;
    bit  bad;
    logic [31:0] er;
    tgt = (w == 0) ? core : w - 1;
    bad = (be != 4'hF) || mis || (w == 0 && core >= N) || (w > N);
    @(negedge clk);
    req_valid = 1'b1; req_core = CW'(core); req_addr = wa(w, o) | (mis ? AW'(2) : AW'(0));
    req_we = we; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    er = (bad || we) ? 32'h0 : mdl[tgt][o];
    if (!bad && we) mdl[tgt][o] = d;
    chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, rsp_valid, 1);
    chk(rsp_err == bad, {tag, " rsp_err"}, rsp_err, bad);
    chk(acc_err == bad, {tag, " acc_err"}, acc_err, bad);
    chk(rsp_rdata == er, {tag, " rdata"}, rsp_rdata, er);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) for (int j = 0; j < 8; j++) mdl[k][j] = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && acc_err == 0 && irq_o == 0, "R11 reset outputs", {rsp_valid, acc_err, irq_o}, 0);
    chk(req_ready == 1, "R11 reset ready", req_ready, 1);
    rst_n = 1'b1;

    // R2, R3: fixed windows, issued from core 0, several offsets
    for (int k = 0; k < N; k++) begin
      access("R2 fixed write", 0, k + 1, 0, 1'b1, 32'hA000_0000 + k, 4'hF, 1'b0);
      access("R3 offset write", 3, k + 1, 5, 1'b1, 32'h0B00_0050 + k, 4'hF, 1'b0);
    end
    // R1: alias reads reach each core's own timer
    for (int k = 0; k < N; k++) begin
      access("R1 alias read", k, 0, 0, 1'b0, 0, 4'hF, 1'b0);
      access("R3 alias offset read", k, 0, 5, 1'b0, 0, 4'hF, 1'b0);
    end
    // R1, R12: alias write from core 2, read back through fixed window 3
    access("R12 alias write", 2, 0, 1, 1'b1, 32'hCAFE_0002, 4'hF, 1'b0);
    access("R1 fixed readback", 0, 3, 1, 1'b0, 0, 4'hF, 1'b0);
    // R4: partial strobes and misaligned address, then prove no write landed
    access("R4 partial be", 1, 1, 0, 1'b1, 32'hDEAD_0001, 4'b0011, 1'b0);
    access("R4 misaligned", 1, 1, 0, 1'b1, 32'hDEAD_0002, 4'hF, 1'b1);
    access("R4 unchanged", 1, 1, 0, 1'b0, 0, 4'hF, 1'b0);
    // R5: alias from a core without a timer
    access("R5 bad core read", 5, 0, 0, 1'b0, 0, 4'hF, 1'b0);
    access("R5 bad core write", 7, 0, 0, 1'b1, 32'h1111_1111, 4'hF, 1'b0);
    // R6: windows beyond the last timer
    access("R6 window N+1", 0, N + 1, 0, 1'b0, 0, 4'hF, 1'b0);
    access("R6 window high", 0, 100, 2, 1'b1, 32'h2222_2222, 4'hF, 1'b0);
    for (int k = 0; k < N; k++) access("R6 no side effect", 0, k + 1, 0, 1'b0, 0, 4'hF, 1'b0);
    // R7: refused access, then legal access; pulse must not stretch
    access("R7 refused", 6, 0, 0, 1'b0, 0, 4'hF, 1'b0);
    access("R7 legal after", 0, 2, 0, 1'b0, 0, 4'hF, 1'b0);
    @(negedge clk);
    chk(acc_err == 0, "R7 pulse ends", acc_err, 0);

    // R8: stalled response, waiting write, simultaneous handoff and accept
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_core = 0; req_addr = wa(1, 0); req_we = 0; req_be = 4'hF;
    @(negedge clk);
    req_addr = wa(2, 6); req_we = 1; req_wdata = 32'h5151_5151;
    for (int i = 0; i < 3; i++) begin
      chk(req_ready == 0, "R8 ready low", req_ready, 0);
      chk(rsp_valid && rsp_rdata == mdl[0][0] && !rsp_err, "R8 held rsp", rsp_rdata, mdl[0][0]);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    mdl[1][6] = 32'h5151_5151;
    chk(rsp_valid && rsp_rdata == 0 && !rsp_err, "R8 next rsp", rsp_rdata, 0);
    access("R8 write once", 0, 2, 6, 1'b0, 0, 4'hF, 1'b0);

    // R10: interrupt from timer 2 via offset 3
    access("R10 set irq", 0, 3, 3, 1'b1, 32'h1, 4'hF, 1'b0);
    @(negedge clk);
    chk(irq_o == 4'b0100, "R10 irq raised", irq_o, 4'b0100);
    access("R10 clear irq", 2, 0, 3, 1'b1, 32'h0, 4'hF, 1'b0);
    @(negedge clk);
    chk(irq_o == 4'b0000, "R10 irq cleared", irq_o, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule